// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of a successive approximation converter. It waits in a track phase while the input capacitor follows the analog signal. When a start request is present and the track phase has lasted long enough, it raises a hold indication. It then runs a bit-by-bit binary search by driving a trial code to an external DAC and reading back a single comparator decision on every clock. When the last bit is decided, the code is formatted and posted to the result register, and the block goes back to tracking.

A start request can come from one of three places, and a two-bit selector picks which one is active: a software start strobe, a timer overflow pulse, or an external start pin that is asynchronous to the clock. A request that cannot be serviced at once is remembered until it can. The result is unsigned in single-ended mode and two's complement in differential mode. The hold output is high for the whole conversion, so the surrounding logic can change multiplexer and gain settings while the sample capacitor is disconnected.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, busy_o, hold_o, done_pulse_o and done_flag_o are 0, and result_o and dac_code_o are all zeros.
- R2: On the first cycle of a conversion, dac_code_o holds only its most significant bit set (half of full scale). While busy_o is low, dac_code_o is zero.
- R3: On each later conversion cycle, the bit tested in the previous cycle keeps the value of cmp_in sampled then (1 means the held sample is at or above the trial code). The next lower bit is set to 1, and all bits below it are 0.
- R4: busy_o stays high for exactly RES_W consecutive cycles per conversion, and hold_o equals busy_o. On the first cycle after busy_o falls, done_pulse_o is high for exactly one cycle.
- R5: Between two conversions, busy_o stays low for at least TRACK_MIN+1 cycles. When a request is already waiting, it stays low for exactly TRACK_MIN+1 cycles.
- R6: src_sel picks the start source: 2'b00 software strobe sw_go, 2'b01 timer pulse tmr_ovf, 2'b10 external pin ext_start, 2'b11 no source. Pulses on sources that are not selected start nothing.
- R7: ext_start is synchronised by two flops and acts only on its rising edge. Holding it high starts a single conversion.
- R8: A request that arrives while a conversion runs, or before the track time is over, is kept pending. It starts a conversion as soon as the track time allows.
- R9: With diff_mode low when the conversion starts, result_o equals the searched code as an unsigned number (full scale reads all ones).
- R10: With diff_mode high when the conversion starts, result_o is two's complement: the searched offset code with its most significant bit inverted. The most positive code is 0 followed by all ones.
- R11: done_flag_o is set when a result is posted and stays set until done_clr is pulsed. A post in the same cycle as done_clr leaves it set.
- R12: result_o changes only in the cycle that done_pulse_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Start source selector (see R6) |
| sw_go | input | 1 | Software start strobe, one cycle |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ext_start | input | 1 | External start pin, asynchronous |
| diff_mode | input | 1 | 1 = differential (two's complement result), 0 = single-ended |
| cmp_in | input | 1 | Comparator decision: 1 when held sample >= dac_code_o |
| done_clr | input | 1 | Write-one strobe that clears done_flag_o |
| dac_code_o | output | RES_W | Trial code to the DAC |
| hold_o | output | 1 | Sample held, input disconnected |
| busy_o | output | 1 | Conversion in progress |
| done_pulse_o | output | 1 | One-cycle result-posted strobe |
| done_flag_o | output | 1 | Sticky result-posted flag |
| result_o | output | RES_W | Last formatted result |

## Verification
The assertions take for granted that cmp_in is a function of the current dac_code_o alone within a conversion, as an ideal comparator would be. They also assume that done_clr and the start strobes are synchronous single-cycle pulses. The bench meets this: it models the comparator combinationally from a fixed digital sample held constant through each conversion, and it drives every strobe for exactly one cycle at the falling clock edge. Only ext_start is held for long stretches, which exercises the edge detection.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        SRC_SW  = 2'b00,
        SRC_TMR = 2'b01,
        SRC_EXT = 2'b10,
        SRC_OFF = 2'b11
    } src_sel_e;

    typedef enum logic {
        PH_TRACK = 1'b0,
        PH_CONV  = 1'b1
    } phase_e;

endpackage

// File: rtl/sar_start_gate.sv
module sar_start_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       sw_go,
    input  logic       tmr_ovf,
    input  logic       ext_start,
    input  logic       launch,
    output logic       req_pending
);
    import sar_pkg::*;

    localparam int SW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    typedef struct packed {
        logic [SW-1:0] sync;
        logic          ext_prev;
        logic          pending;
    } gate_t;

    gate_t st_d, st_q;
    logic  ext_rise;
    logic  trig;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SW-2:0], ext_start};
        st_d.ext_prev = st_q.sync[SW-1];
        ext_rise  = st_q.sync[SW-1] & ~st_q.ext_prev;

        unique case (src_sel_e'(src_sel))
            SRC_SW:  trig = sw_go;
            SRC_TMR: trig = tmr_ovf;
            SRC_EXT: trig = ext_rise;
            default: trig = 1'b0;
        endcase

        // a launch consumes the stored request; a fresh trigger re-arms it
        st_d.pending = (st_q.pending & ~launch) | trig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_pending = st_q.pending;

endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
    parameter int RES_W     = 12,
    parameter int TRACK_MIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_pending,
    input  logic             cmp_in,
    input  logic             diff_mode,
    output logic             launch,
    output logic             conv_active,
    output logic [RES_W-1:0] trial_code,
    output logic             post_now,
    output logic [RES_W-1:0] final_code,
    output logic             diff_latched
);
    import sar_pkg::*;

    localparam int TRK_W = (TRACK_MIN < 1) ? 1 : $clog2(TRACK_MIN + 1);
    localparam int IDX_W = (RES_W < 2) ? 1 : $clog2(RES_W);
    localparam logic [TRK_W-1:0] TRK_END = TRK_W'(TRACK_MIN);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(RES_W - 1);
    localparam logic [RES_W-1:0] HALF_SCALE = {1'b1, {(RES_W-1){1'b0}}};

    typedef struct packed {
        phase_e           phase;
        logic [TRK_W-1:0] trk;
        logic [RES_W-1:0] trial;
        logic [IDX_W-1:0] idx;
        logic             diff;
    } eng_t;

    eng_t             st_d, st_q;
    logic [RES_W-1:0] decided;

    always_comb begin
        st_d     = st_q;
        launch   = (st_q.phase == PH_TRACK) && (st_q.trk == TRK_END) && req_pending;
        post_now = (st_q.phase == PH_CONV) && (st_q.idx == '0);

        decided = st_q.trial;
        decided[st_q.idx] = cmp_in;

        unique case (st_q.phase)
            PH_TRACK: begin
                if (st_q.trk != TRK_END) begin
                    st_d.trk = st_q.trk + 1'b1;
                end
                if (launch) begin
                    st_d.phase = PH_CONV;
                    st_d.trial = HALF_SCALE;
                    st_d.idx   = IDX_TOP;
                    st_d.diff  = diff_mode;
                end
            end
            PH_CONV: begin
                if (st_q.idx == '0) begin
                    st_d.phase = PH_TRACK;
                    st_d.trial = '0;
                    st_d.trk   = '0;
                end else begin
                    st_d.trial = decided;
                    st_d.trial[st_q.idx - 1'b1] = 1'b1;
                    st_d.idx   = st_q.idx - 1'b1;
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign conv_active  = (st_q.phase == PH_CONV);
    assign trial_code   = st_q.trial;
    assign final_code   = decided;
    assign diff_latched = st_q.diff;

endmodule

// File: rtl/sar_result_fmt.sv
module sar_result_fmt #(
    parameter int RES_W = 12
) (
    input  logic [RES_W-1:0] raw_code,
    input  logic             diff,
    output logic [RES_W-1:0] fmt_code
);
    // differential search runs on an offset scale: flipping the top bit
    // turns offset binary into two's complement
    always_comb begin
        fmt_code = raw_code;
        if (diff) begin
            fmt_code[RES_W-1] = ~raw_code[RES_W-1];
        end
    end

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
    parameter int RES_W       = 12,
    parameter int TRACK_MIN   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       src_sel,
    input  logic             sw_go,
    input  logic             tmr_ovf,
    input  logic             ext_start,
    input  logic             diff_mode,
    input  logic             cmp_in,
    input  logic             done_clr,
    output logic [RES_W-1:0] dac_code_o,
    output logic             hold_o,
    output logic             busy_o,
    output logic             done_pulse_o,
    output logic             done_flag_o,
    output logic [RES_W-1:0] result_o
);

    typedef struct packed {
        logic             done_pulse;
        logic             done_flag;
        logic [RES_W-1:0] result;
    } post_t;

    post_t            pst_d, pst_q;
    logic             req_pending;
    logic             launch;
    logic             conv_active;
    logic [RES_W-1:0] trial_code;
    logic             post_now;
    logic [RES_W-1:0] final_code;
    logic             diff_latched;
    logic [RES_W-1:0] fmt_code;

    sar_start_gate #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_sel    (src_sel),
        .sw_go      (sw_go),
        .tmr_ovf    (tmr_ovf),
        .ext_start  (ext_start),
        .launch     (launch),
        .req_pending(req_pending)
    );

    sar_engine #(
        .RES_W    (RES_W),
        .TRACK_MIN(TRACK_MIN)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_pending (req_pending),
        .cmp_in      (cmp_in),
        .diff_mode   (diff_mode),
        .launch      (launch),
        .conv_active (conv_active),
        .trial_code  (trial_code),
        .post_now    (post_now),
        .final_code  (final_code),
        .diff_latched(diff_latched)
    );

    sar_result_fmt #(
        .RES_W(RES_W)
    ) u_fmt (
        .raw_code(final_code),
        .diff    (diff_latched),
        .fmt_code(fmt_code)
    );

    always_comb begin
        pst_d            = pst_q;
        pst_d.done_pulse = post_now;
        if (post_now) begin
            pst_d.done_flag = 1'b1;
            pst_d.result    = fmt_code;
        end else if (done_clr) begin
            pst_d.done_flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pst_q <= '0;
        end else begin
            pst_q <= pst_d;
        end
    end

    assign dac_code_o   = trial_code;
    assign hold_o       = conv_active;
    assign busy_o       = conv_active;
    assign done_pulse_o = pst_q.done_pulse;
    assign done_flag_o  = pst_q.done_flag;
    assign result_o     = pst_q.result;

endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
    parameter int RES_W     = 12,
    parameter int TRACK_MIN = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic [RES_W-1:0] dac_code_o,
    input logic             done_pulse_o,
    input logic             done_flag_o,
    input logic             done_clr,
    input logic [RES_W-1:0] result_o
);
    localparam int CNT_W = $clog2(RES_W + TRACK_MIN + 4) + 1;
    localparam logic [CNT_W-1:0] LEN_EXP  = CNT_W'(RES_W);
    localparam logic [CNT_W-1:0] IDLE_MIN = CNT_W'(TRACK_MIN);
    localparam logic [RES_W-1:0] HALF_SCALE = {1'b1, {(RES_W-1){1'b0}}};

    logic [CNT_W-1:0] busy_cnt_q;
    logic [CNT_W-1:0] idle_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt_q <= '0;
            idle_cnt_q <= '0;
        end else begin
            busy_cnt_q <= busy_o ? busy_cnt_q + 1'b1 : '0;
            if (busy_o) begin
                idle_cnt_q <= '0;
            end else if (idle_cnt_q != IDLE_MIN) begin
                idle_cnt_q <= idle_cnt_q + 1'b1;
            end
        end
    end

    p_first_trial_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> dac_code_o == HALF_SCALE);

    p_idle_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> dac_code_o == '0);

    p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> busy_cnt_q == LEN_EXP);

    p_done_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_pulse_o);

    p_done_only_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse_o |-> $fell(busy_o));

    p_track_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> idle_cnt_q >= IDLE_MIN);

    p_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse_o |-> done_flag_o);

    p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done_clr) && !done_pulse_o) |-> !done_flag_o);

    p_result_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !done_pulse_o |-> $stable(result_o));

endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(
    .RES_W    (RES_W),
    .TRACK_MIN(TRACK_MIN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .dac_code_o  (dac_code_o),
    .done_pulse_o(done_pulse_o),
    .done_flag_o (done_flag_o),
    .done_clr    (done_clr),
    .result_o    (result_o)
);

// File: tb/tb_sar_conv_ctrl.sv
`timescale 1ns/1ps
module tb_sar_conv_ctrl;

    localparam int RES_W     = 12;
    localparam int TRACK_MIN = 4;
    localparam int NVEC      = 9;
    localparam logic [RES_W-1:0] MSB = 12'h800;

    // {diff_mode, sample code on the offset/unsigned scale}
    localparam logic [RES_W:0] VEC [NVEC] = '{
        {1'b0, 12'h000}, {1'b0, 12'hFFF}, {1'b0, 12'h800},
        {1'b0, 12'h7FF}, {1'b0, 12'h123},
        {1'b1, 12'hFFF}, {1'b1, 12'h000}, {1'b1, 12'h7FF},
        {1'b1, 12'h800}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       src_sel = 2'b00;
    logic             sw_go = 1'b0;
    logic             tmr_ovf = 1'b0;
    logic             ext_start = 1'b0;
    logic             diff_mode = 1'b0;
    logic             cmp_in;
    logic             done_clr = 1'b0;
    logic [RES_W-1:0] dac_code_o;
    logic             hold_o;
    logic             busy_o;
    logic             done_pulse_o;
    logic             done_flag_o;
    logic [RES_W-1:0] result_o;
    logic [RES_W-1:0] sample_u = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    // ideal comparator against the held digital sample
    assign cmp_in = (sample_u >= dac_code_o);

    sar_conv_ctrl #(
        .RES_W    (RES_W),
        .TRACK_MIN(TRACK_MIN)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_sel     (src_sel),
        .sw_go       (sw_go),
        .tmr_ovf     (tmr_ovf),
        .ext_start   (ext_start),
        .diff_mode   (diff_mode),
        .cmp_in      (cmp_in),
        .done_clr    (done_clr),
        .dac_code_o  (dac_code_o),
        .hold_o      (hold_o),
        .busy_o      (busy_o),
        .done_pulse_o(done_pulse_o),
        .done_flag_o (done_flag_o),
        .result_o    (result_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_busy(input int limit);
        for (int k = 0; k < limit && !busy_o; k++) @(negedge clk);
    endtask

    task automatic pulse_sw();
        @(negedge clk); sw_go = 1'b1;
        @(negedge clk); sw_go = 1'b0;
    endtask

    // runs one software-started conversion and checks it end to end
    task automatic run_conv(input logic [RES_W-1:0] u, input logic diff);
        int n;
        int idx;
        int exp_trial;
        logic [RES_W-1:0] exp_res;
        sample_u  = u;
        diff_mode = diff;
        src_sel   = 2'b00;
        pulse_sw();
        wait_busy(40);
        chk(busy_o == 1'b1, "R6 sw start", busy_o, 1);
        chk(dac_code_o == MSB, "R2 first trial", dac_code_o, MSB);
        n = 0;
        idx = RES_W - 1;
        while (busy_o && n < 40) begin
            exp_trial = ((int'(u) >> (idx + 1)) << (idx + 1)) | (1 << idx);
            chk(dac_code_o == exp_trial[RES_W-1:0], "R3 trial", dac_code_o, exp_trial);
            chk(hold_o == 1'b1, "R4 hold", hold_o, 1);
            n++;
            idx--;
            @(negedge clk);
        end
        chk(n == RES_W, "R4 busy length", n, RES_W);
        chk(done_pulse_o == 1'b1, "R4 done pulse", done_pulse_o, 1);
        chk(hold_o == 1'b0, "R4 hold off", hold_o, 0);
        chk(done_flag_o == 1'b1, "R11 flag set", done_flag_o, 1);
        exp_res = diff ? (u ^ MSB) : u;
        if (diff) chk(result_o == exp_res, "R10 diff result", result_o, exp_res);
        else      chk(result_o == exp_res, "R9 se result", result_o, exp_res);
        @(negedge clk);
        chk(done_pulse_o == 1'b0, "R4 pulse width", done_pulse_o, 0);
    endtask

    initial begin
        int cnt;
        int rises;
        logic prev;
        logic [RES_W-1:0] keep;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy_o == 0 && hold_o == 0, "R1 busy/hold", {busy_o, hold_o}, 0);
        chk(done_pulse_o == 0 && done_flag_o == 0, "R1 done", {done_pulse_o, done_flag_o}, 0);
        chk(result_o == 0, "R1 result", result_o, 0);
        chk(dac_code_o == 0, "R1 dac", dac_code_o, 0);
        rst_n = 1'b1;

        // table-driven conversions (R2 R3 R4 R9 R10)
        for (int i = 0; i < NVEC; i++) begin
            run_conv(VEC[i][RES_W-1:0], VEC[i][RES_W]);
        end

        // R11 write-one-to-clear, flag sticky until then
        repeat (5) @(negedge clk);
        chk(done_flag_o == 1'b1, "R11 sticky", done_flag_o, 1);
        done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
        chk(done_flag_o == 1'b0, "R11 cleared", done_flag_o, 0);

        // R12 result holds while sample changes and nothing posts
        keep = result_o;
        sample_u = 12'h5A5;
        repeat (10) @(negedge clk);
        chk(result_o == keep, "R12 result stable", result_o, keep);

        // R8 request during conversion is served; R5 exact track gap
        sample_u = 12'h3C3; diff_mode = 1'b0; src_sel = 2'b00;
        pulse_sw();
        wait_busy(40);
        pulse_sw();
        while (busy_o) @(negedge clk);
        cnt = 0;
        while (!busy_o && cnt < 40) begin cnt++; @(negedge clk); end
        chk(busy_o == 1'b1, "R8 pending served", busy_o, 1);
        chk(cnt == TRACK_MIN + 1, "R5 track gap", cnt, TRACK_MIN + 1);
        while (busy_o) @(negedge clk);
        chk(result_o == 12'h3C3, "R8 result", result_o, 12'h3C3);

        // R6 unselected timer pulse ignored
        repeat (10) @(negedge clk);
        src_sel = 2'b00;
        @(negedge clk); tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0;
        cnt = 0;
        for (int k = 0; k < 20; k++) begin if (busy_o) cnt++; @(negedge clk); end
        chk(cnt == 0, "R6 timer ignored", cnt, 0);
        // R6 no-source code ignores software strobe
        src_sel = 2'b11;
        pulse_sw();
        cnt = 0;
        for (int k = 0; k < 20; k++) begin if (busy_o) cnt++; @(negedge clk); end
        chk(cnt == 0, "R6 off ignores sw", cnt, 0);
        // R6 timer selected starts
        src_sel = 2'b01;
        @(negedge clk); tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0;
        wait_busy(20);
        chk(busy_o == 1'b1, "R6 timer start", busy_o, 1);
        while (busy_o) @(negedge clk);

        // R7 external pin held high starts exactly one conversion
        repeat (10) @(negedge clk);
        src_sel = 2'b10;
        ext_start = 1'b1;
        rises = 0; prev = busy_o;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (busy_o && !prev) rises++;
            prev = busy_o;
        end
        chk(rises == 1, "R7 single start", rises, 1);
        ext_start = 1'b0;
        repeat (5) @(negedge clk);
        ext_start = 1'b1;
        rises = 0; prev = busy_o;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (busy_o && !prev) rises++;
            prev = busy_o;
        end
        chk(rises == 1, "R7 second edge", rises, 1);
        ext_start = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule